// File: doc/BRIEF.md
# Banked GPIO Register File with Atomic Alias Windows

This block is the software-visible register file for one bank of general-purpose pins. It keeps a drive-level register and a drive-enable register, and it has a read-only register that shows the pin levels after a two-flop synchronizer. A pin drives when its enable bit is 1 and is an input when the bit is 0. Bit n of every register belongs to pin n of the bank.

Each writable register can be reached through four address windows. Bits 13:12 of the byte address pick the window. In the plain window a write replaces the register. In the toggle window it inverts the bits where the data is 1, in the set window it ORs the data in, and in the clear window it clears the bits where the data is 1. Software can therefore change the direction or level of one pin without a read-modify-write, so two agents that share a bank cannot lose each other's updates.

The bus is a simple synchronous port with one address, a write strobe, write data and combinational read data. A write takes effect at the clock edge where `we_i` is high. A read returns the addressed register in the same cycle, whatever the window.

Top module: `gpio_bank_regs`

## Requirements
- R1: After the asynchronous reset `rst_ni` is asserted, the drive-level register, the drive-enable register and the synchronizer are 0. `pin_out_o`, `pin_oe_o` and every read return 0.
- R2: A write in the plain window (address bits 13:12 = 0) replaces the addressed register with `wdata_i`. The new value appears on the pins after that clock edge.
- R3: A write in the toggle window (bits 13:12 = 1) inverts exactly the register bits where `wdata_i` is 1.
- R4: A write in the set window (bits 13:12 = 2) ORs `wdata_i` into the register.
- R5: A write in the clear window (bits 13:12 = 3) ANDs the inverse of `wdata_i` into the register.
- R6: Register word offsets within a window: drive level at byte 0x00, drive enable at 0x04, input level at 0x08. Bit n maps to pin n, and a drive-enable bit of 1 makes the pin an output.
- R7: A read at any of the four windows returns the current contents of the addressed register in the same cycle, and a read changes no state.
- R8: The input-level register shows `pin_in_i` through two flops. A level change before clock edge k is visible on a read after edge k+1 and not after edge k.
- R9: Writes to the input-level register, and writes to unmapped addresses, change no register. An unmapped address is one with a nonzero byte offset inside the word, a word index above 2, or nonzero bits 11:4. A read of an unmapped address returns 0.
- R10: Register bits at or above `NUM_PINS` are not stored and always read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address: window in bits 13:12, word in bits 11:2 |
| we_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| pin_out_o | output | NUM_PINS | Drive level per pin |
| pin_oe_o | output | NUM_PINS | Drive enable per pin, 1 = output |
| pin_in_i | input | NUM_PINS | Raw pin levels, asynchronous |

## Verification
The register contents are wired straight to `pin_out_o` and `pin_oe_o`, so a wrong alias operation or a wrong decode shows on the pins right after the offending write edge. Reading the same register through all four windows then shows whether the read path agrees with the pins. A synchronizer that is too short or too long shows up as an input change that becomes visible one edge early or late. Bits above the bank width that have been stored by mistake show on the upper bits of read data after a write with all data bits set.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    WIN_PLAIN = 2'd0,
    WIN_TGL   = 2'd1,
    WIN_SET   = 2'd2,
    WIN_CLR   = 2'd3
  } win_e;

  localparam int unsigned WIN_LSB  = 12;
  localparam int unsigned WORD_LSB = 2;
  localparam int unsigned NUM_WORDS = 3;

  typedef enum logic [1:0] {
    SEL_OUT  = 2'd0,
    SEL_OE   = 2'd1,
    SEL_IN   = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;
endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] addr_i,
  output win_e              win_o,
  output sel_e              sel_o
);
  localparam int unsigned IDX_W = WIN_LSB - WORD_LSB;

  logic [IDX_W-1:0] word_idx;
  logic             hi_zero;

  assign win_o    = win_e'(addr_i[WIN_LSB+1:WIN_LSB]);
  assign word_idx = addr_i[WIN_LSB-1:WORD_LSB];

  generate
    if (ADDR_W > WIN_LSB + 2) begin : g_hi
      assign hi_zero = ~|addr_i[ADDR_W-1:WIN_LSB+2];
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    sel_o = SEL_NONE;
    if (hi_zero && addr_i[WORD_LSB-1:0] == '0) begin
      unique case (word_idx)
        IDX_W'(0): sel_o = SEL_OUT;
        IDX_W'(1): sel_o = SEL_OE;
        IDX_W'(2): sel_o = SEL_IN;
        default:   sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_wreg.sv
module gpio_bank_wreg
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  win_e             win_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] nxt;

  always_comb begin
    unique case (win_i)
      WIN_PLAIN: nxt = data_i;
      WIN_TGL:   nxt = q_o ^ data_i;
      WIN_SET:   nxt = q_o | data_i;
      WIN_CLR:   nxt = q_o & ~data_i;
      default:   nxt = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= nxt;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  input  logic [NUM_PINS-1:0] pin_in_i
);
  localparam int unsigned PAD_W = DATA_W - NUM_PINS;

  win_e                win;
  sel_e                sel;
  logic [NUM_PINS-1:0] in_sync;
  logic [NUM_PINS-1:0] rd_bits;

  gpio_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .win_o  (win),
    .sel_o  (sel)
  );

  gpio_bank_wreg #(.WIDTH(NUM_PINS)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (we_i && sel == SEL_OUT),
    .win_i  (win),
    .data_i (wdata_i[NUM_PINS-1:0]),
    .q_o    (pin_out_o)
  );

  gpio_bank_wreg #(.WIDTH(NUM_PINS)) u_oe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (we_i && sel == SEL_OE),
    .win_i  (win),
    .data_i (wdata_i[NUM_PINS-1:0]),
    .q_o    (pin_oe_o)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_in_i),
    .q_o    (in_sync)
  );

  always_comb begin
    unique case (sel)
      SEL_OUT: rd_bits = pin_out_o;
      SEL_OE:  rd_bits = pin_oe_o;
      SEL_IN:  rd_bits = in_sync;
      default: rd_bits = '0;
    endcase
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdata_o = {{PAD_W{1'b0}}, rd_bits};
    end else begin : g_full
      assign rdata_o = rd_bits;
    end
  endgenerate
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 14
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                we_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [NUM_PINS-1:0] pin_out_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic [NUM_PINS-1:0] pin_in_i
);
  logic [1:0]          win;
  logic                a_out, a_oe, a_in;
  logic [NUM_PINS-1:0] wd;
  logic [1:0]          age;

  assign win   = addr_i[13:12];
  assign a_out = ({addr_i[ADDR_W-1:14 > ADDR_W-1 ? ADDR_W-1 : 14] , 1'b0} == '0 || ADDR_W <= 14)
                 && addr_i[11:0] == 12'h000;
  assign a_oe  = addr_i[11:0] == 12'h004;
  assign a_in  = addr_i[11:0] == 12'h008;
  assign wd    = wdata_i[NUM_PINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (pin_out_o == '0 && pin_oe_o == '0);
    end
  end

  assert_plain_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ADDR_W == 14 && we_i && win == 2'd0 && a_out) |=> pin_out_o == $past(wd));

  assert_toggle_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ADDR_W == 14 && we_i && win == 2'd1 && a_oe) |=> pin_oe_o == ($past(pin_oe_o) ^ $past(wd)));

  assert_set_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ADDR_W == 14 && we_i && win == 2'd2 && a_oe) |=> pin_oe_o == ($past(pin_oe_o) | $past(wd)));

  assert_clear_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ADDR_W == 14 && we_i && win == 2'd3 && a_out) |=> pin_out_o == ($past(pin_out_o) & ~$past(wd)));

  assert_input_sync_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ADDR_W == 14 && age == 2'd3 && a_in) |-> rdata_o[NUM_PINS-1:0] == $past(pin_in_i, 2));

  assert_in_wr_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && a_in) |=> ($stable(pin_out_o) && $stable(pin_oe_o)));

  generate
    if (NUM_PINS < DATA_W) begin : g_hi
      assert_upper_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdata_o[DATA_W-1:NUM_PINS] == '0);
    end
  endgenerate
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pin_out_o (pin_out_o),
  .pin_oe_o  (pin_oe_o),
  .pin_in_i  (pin_in_i)
);

// File: tb/sim_gpio_bank_regs.sv
`timescale 1ns/1ps
module sim_gpio_bank_regs;
  localparam int unsigned NP = 6;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 14;
  localparam logic [DW-1:0] PMASK = (DW'(1) << NP) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          we_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic [NP-1:0] pin_out_o, pin_oe_o;
  logic [NP-1:0] pin_in_i = '0;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] m_out = '0;
  logic [DW-1:0] m_oe = '0;

  always #5 clk_i = ~clk_i;

  gpio_bank_regs #(.NUM_PINS(NP), .DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_out_o(pin_out_o),
    .pin_oe_o(pin_oe_o), .pin_in_i(pin_in_i)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(input int win, input int word);
    return AW'((win << 12) | (word << 2));
  endfunction

  function automatic logic [DW-1:0] alias_op(input int win, input logic [DW-1:0] q,
                                             input logic [DW-1:0] d);
    case (win)
      0: return d & PMASK;
      1: return (q ^ d) & PMASK;
      2: return (q | d) & PMASK;
      default: return q & ~d & PMASK;
    endcase
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic check_regs(input string req);
    logic [DW-1:0] v;
    chk(req, DW'(pin_out_o), m_out);
    chk(req, DW'(pin_oe_o), m_oe);
    for (int w = 0; w < 4; w++) begin
      rd(mk_addr(w, 0), v); chk({req, " R7 read out"}, v, m_out);
      rd(mk_addr(w, 1), v); chk({req, " R7 read oe"}, v, m_oe);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk_i);
    // R1: reset values
    chk("R1 pin_out", DW'(pin_out_o), '0);
    chk("R1 pin_oe", DW'(pin_oe_o), '0);
    for (int w = 0; w < 4; w++)
      for (int r = 0; r < 3; r++) begin
        rd(mk_addr(w, r), v); chk("R1 read", v, '0);
      end
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R2-R6, R10: sweep windows x registers x all pin patterns with junk upper bits
    for (int w = 0; w < 4; w++)
      for (int r = 0; r < 2; r++)
        for (int p = 0; p < (1 << NP); p++) begin
          logic [DW-1:0] d;
          d = DW'(p) | (DW'(32'hA5C3_0F00 * (p + 1)) & ~PMASK);
          wr(mk_addr(w, r), d);
          if (r == 0) m_out = alias_op(w, m_out, d);
          else        m_oe  = alias_op(w, m_oe, d);
          case (w)
            0: check_regs("R2 R6 R10 plain");
            1: check_regs("R3 R6 R10 toggle");
            2: check_regs("R4 R6 R10 set");
            default: check_regs("R5 R6 R10 clear");
          endcase
        end

    // R6: one-hot pin mapping via set/clear windows
    wr(mk_addr(0, 0), '0); m_out = '0;
    wr(mk_addr(0, 1), '0); m_oe = '0;
    for (int n = 0; n < NP; n++) begin
      wr(mk_addr(2, 1), DW'(1) << n); m_oe = m_oe | (DW'(1) << n);
      chk("R6 oe set bit", DW'(pin_oe_o), m_oe);
      wr(mk_addr(2, 0), DW'(1) << n); m_out = m_out | (DW'(1) << n);
      chk("R6 out set bit", DW'(pin_out_o), m_out);
    end
    for (int n = 0; n < NP; n++) begin
      wr(mk_addr(3, 1), DW'(1) << n); m_oe = m_oe & ~(DW'(1) << n);
      chk("R6 oe clear bit", DW'(pin_oe_o), m_oe);
    end

    // R9: writes to input register and unmapped addresses ignored
    wr(mk_addr(0, 0), 32'h15); m_out = 32'h15;
    wr(mk_addr(0, 1), 32'h2A); m_oe = 32'h2A;
    for (int w = 0; w < 4; w++) begin
      wr(mk_addr(w, 2), 32'hFFFF_FFFF);
      check_regs("R9 input write");
      wr(mk_addr(w, 3), 32'hFFFF_FFFF);
      check_regs("R9 word3 write");
      wr(AW'((w << 12) | 12'h801), 32'hFFFF_FFFF);
      check_regs("R9 misaligned write");
      wr(AW'((w << 12) | 12'h010), 32'h0);
      check_regs("R9 high word write");
      rd(AW'((w << 12) | 12'h00C), v); chk("R9 unmapped read", v, '0);
      rd(AW'((w << 12) | 12'h400), v); chk("R9 unmapped read hi", v, '0);
      rd(AW'((w << 12) | 12'h002), v); chk("R9 unaligned read", v, '0);
    end

    // R8: two-flop input latency, all input patterns
    for (int p = 0; p < (1 << NP); p++) begin
      logic [DW-1:0] prev;
      logic [DW-1:0] nv;
      @(negedge clk_i);
      rd(mk_addr(0, 2), prev);
      nv = DW'((p * 37 + 5) % (1 << NP));
      pin_in_i = NP'(nv);
      @(negedge clk_i);
      rd(mk_addr(p % 4, 2), v); chk("R8 after one edge", v, prev);
      @(negedge clk_i);
      rd(mk_addr(p % 4, 2), v); chk("R8 after two edges", v, nv);
    end

    // R1: asynchronous reset clears state mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    chk("R1 async pin_out", DW'(pin_out_o), '0);
    chk("R1 async pin_oe", DW'(pin_oe_o), '0);
    rd(mk_addr(0, 2), v); chk("R1 async input", v, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule